// File: doc/BRIEF.md
# Fixed-Period PWM Current Chopper for One Motor Winding

This block controls the four gates of one H-bridge that drives a single stepper winding. It runs a PWM cycle of fixed length, counted in clock cycles. Each cycle opens with a drive phase: the bridge pushes current in the direction the indexer commands. A blanking window follows the start of drive. During that window the sense comparator is ignored, and the same window sets the minimum on time. After blanking, a comparator trip ends the drive phase, and the rest of the cycle is spent in decay.

The decay type depends on the select input and on whether the table current is falling:

- **Slow decay** turns on both low-side switches. It is always used when the select input is low, and it is also used on steps where the current rises.
- **Mixed decay** applies only when the select input is high and the current is falling. It first reverses the bridge (fast decay) and then moves to slow decay at a fixed fraction of the period. A zero-current indication during fast decay switches the bridge off for the rest of the cycle, so that no reverse current builds up.

A table level of zero skips drive and keeps the winding in slow decay for the whole cycle.

Every switch on either half-bridge passes through a break-before-make gap. During the gap both switches of that half-bridge are off, which prevents shoot-through. The analog comparator, the reference DAC and the gate drivers are outside the block.

Top module: `chop_winding_ctrl`

## Requirements
- R1: With `enable` high and `level` nonzero, every PWM cycle lasts PERIOD_CYC clocks and begins with a drive phase, whatever happened in the cycle before.
- R2: A trip is ignored during the first BLANK_CYC clocks of the drive phase, so drive lasts at least BLANK_CYC clocks. Without any trip, drive lasts the whole cycle.
- R3: Gate vector {hs1,ls1,hs2,ls2}. Drive with `dir_pos`=1 gives 1001, and drive with `dir_pos`=0 gives 0110. Gates follow the phase one clock later, so the first drive gates appear on the second rising edge after `enable` is sampled high.
- R4: A trip after blanking, when `mixed_sel`=0 or `cur_falling`=0, moves the bridge into slow decay, gate vector 0101.
- R5: A trip after blanking, when `mixed_sel`=1 and `cur_falling`=1, starts fast decay: the reversed bridge, 0110 for `dir_pos`=1. Fast decay lasts until count MIX_AT = PERIOD_CYC*MIX_PCT/100, measured from the cycle start, and slow decay follows it.
- R6: A trip that is seen at or after count MIX_AT-1 in mixed mode goes directly to slow decay.
- R7: `zero_hit` high during fast decay turns all four gates off until the cycle ends.
- R8: `level`=0 at the cycle start gives slow decay (0101) for the whole cycle, with no drive.
- R9: With `enable` low, all gates are off no later than two clocks after it is sampled low. Raising `enable` again starts a new cycle.
- R10: When a half-bridge changes from one conducting switch to the other, both of its switches stay off for DEAD_CYC clocks first. The high-side and low-side of a half-bridge are never on together.
- R11: Synchronous reset turns all gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High runs the bridge; low turns all gates off |
| dir_pos | input | 1 | Commanded current sign; 1 drives out1 positive |
| level | input | LVL_W | Table current level; zero means no drive |
| mixed_sel | input | 1 | 0 = slow decay always, 1 = mixed on falling steps |
| cur_falling | input | 1 | Table current is decreasing on this step |
| trip | input | 1 | Digital chopping-comparator trip |
| zero_hit | input | 1 | Winding current has reached zero |
| hs1 | output | 1 | High-side gate, half-bridge 1 |
| ls1 | output | 1 | Low-side gate, half-bridge 1 |
| hs2 | output | 1 | High-side gate, half-bridge 2 |
| ls2 | output | 1 | Low-side gate, half-bridge 2 |

## Verification
The bench builds the block with PERIOD_CYC=40, BLANK_CYC=6, MIX_PCT=75 (which puts the fast-to-slow switch at count 30) and DEAD_CYC=2. With these values a full cycle, the period wrap, both dead-time gaps and the fast-to-slow handover all happen within a few dozen clocks. Each of them can then be sampled at its exact cycle, including a trip held during blanking, a trip landing after the mix point and a zero crossing in fast decay.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_DRIVE = 3'd1,
        PH_FAST  = 3'd2,
        PH_SLOW  = 3'd3,
        PH_HIZ   = 3'd4
    } phase_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } leg_t;

    typedef struct packed {
        leg_t leg1;
        leg_t leg2;
    } bridge_t;

    localparam leg_t LEG_OFF  = '{hs: 1'b0, ls: 1'b0};
    localparam leg_t LEG_HIGH = '{hs: 1'b1, ls: 1'b0};
    localparam leg_t LEG_LOW  = '{hs: 1'b0, ls: 1'b1};

    // Requested gate pattern for a phase and a commanded current sign.
    function automatic bridge_t phase_gates(phase_e ph, logic pos);
        bridge_t b;
        b.leg1 = LEG_OFF;
        b.leg2 = LEG_OFF;
        case (ph)
            PH_DRIVE: begin
                b.leg1 = pos ? LEG_HIGH : LEG_LOW;
                b.leg2 = pos ? LEG_LOW  : LEG_HIGH;
            end
            PH_FAST: begin
                b.leg1 = pos ? LEG_LOW  : LEG_HIGH;
                b.leg2 = pos ? LEG_HIGH : LEG_LOW;
            end
            PH_SLOW: begin
                b.leg1 = LEG_LOW;
                b.leg2 = LEG_LOW;
            end
            default: begin
                b.leg1 = LEG_OFF;
                b.leg2 = LEG_OFF;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/chop_cycle_timer.sv
module chop_cycle_timer #(
    parameter int PERIOD_CYC = 1000,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    assign wrap = (cnt == LAST);

    // Parked at the last count while stopped, so the first running edge opens a cycle.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= LAST;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < PERIOD_CYC);

    assert_wrap_restarts_R1: assert property (@(posedge clk) disable iff (rst)
        (wrap && run) |=> (cnt == '0));

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 1000,
    parameter int BLANK_CYC  = 188,
    parameter int MIX_AT     = 750,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             level_zero,
    input  logic             mixed_sel,
    input  logic             cur_falling,
    input  logic             trip,
    input  logic             zero_hit,
    output phase_e           phase
);
    localparam int BLANK_LAST = BLANK_CYC - 1;
    localparam int MIX_LAST   = MIX_AT - 1;

    phase_e phase_nx;
    logic   blank_done;
    logic   before_mix;
    logic   use_fast;

    assign blank_done = (int'(cnt) >= BLANK_LAST);
    assign before_mix = (int'(cnt) < MIX_LAST);
    assign use_fast   = mixed_sel && cur_falling && before_mix;

    always_comb begin
        phase_nx = phase;
        if (!run) begin
            phase_nx = PH_OFF;
        end else if (wrap) begin
            phase_nx = level_zero ? PH_SLOW : PH_DRIVE;
        end else begin
            case (phase)
                PH_DRIVE: if (trip && blank_done)
                              phase_nx = use_fast ? PH_FAST : PH_SLOW;
                PH_FAST:  if (zero_hit)
                              phase_nx = PH_HIZ;
                          else if (!before_mix)
                              phase_nx = PH_SLOW;
                default:  phase_nx = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_OFF;
        else     phase <= phase_nx;
    end

    // Drive is never left for decay before blanking is over.
    assert_blank_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_FAST || phase == PH_SLOW) && $past(phase) == PH_DRIVE && cnt != '0)
        |-> (int'(cnt) >= BLANK_CYC));

    // Fast decay is entered only with mixed mode on a falling step.
    assert_fast_needs_mixed_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FAST && $past(phase) != PH_FAST) |-> $past(mixed_sel && cur_falling));

    // Fast decay never reaches the mix point.
    assert_fast_before_mix_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FAST) |-> (int'(cnt) < MIX_AT));

    // The zero-current off state is reached only from fast decay.
    assert_hiz_from_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIZ && $past(phase) != PH_HIZ) |-> ($past(phase) == PH_FAST));

endmodule

// File: rtl/chop_dead_leg.sv
module chop_dead_leg
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  leg_t req,
    output leg_t gate
);
    localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC + 1) : 1;

    logic [DW-1:0] hold;

    // Any change first drops both switches; a switch turns on only after the gap.
    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= LEG_OFF;
            hold <= '0;
        end else if (req != gate) begin
            if (gate != LEG_OFF) begin
                gate <= LEG_OFF;
                hold <= DW'(DEAD_CYC - 1);
            end else if (hold != '0) begin
                hold <= hold - 1'b1;
            end else begin
                gate <= req;
            end
        end else if (hold != '0) begin
            hold <= hold - 1'b1;
        end
    end

    // Checker state: consecutive off clocks, and whether the leg has conducted yet.
    logic [DW-1:0] off_run;
    logic          seen_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_run <= '0;
            seen_on <= 1'b0;
        end else begin
            if (gate != LEG_OFF) off_run <= '0;
            else if (off_run != DW'(DEAD_CYC)) off_run <= off_run + 1'b1;
            if (gate != LEG_OFF) seen_on <= 1'b1;
        end
    end

    assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (rst)
        !(gate.hs && gate.ls));

    assert_dead_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (gate != LEG_OFF && $past(gate) == LEG_OFF && seen_on) |-> (off_run >= DW'(DEAD_CYC)));

    assert_req_legal_R10: assert property (@(posedge clk) disable iff (rst)
        !(req.hs && req.ls));

endmodule

// File: rtl/chop_winding_ctrl.sv
module chop_winding_ctrl
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 1000,
    parameter int BLANK_CYC  = 188,
    parameter int MIX_PCT    = 75,
    parameter int DEAD_CYC   = 4,
    parameter int LVL_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             dir_pos,
    input  logic [LVL_W-1:0] level,
    input  logic             mixed_sel,
    input  logic             cur_falling,
    input  logic             trip,
    input  logic             zero_hit,
    output logic             hs1,
    output logic             ls1,
    output logic             hs2,
    output logic             ls2
);
    localparam int CNT_W  = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int MIX_AT = (PERIOD_CYC * MIX_PCT) / 100;

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    phase_e           phase;
    bridge_t          req;
    leg_t             req_leg  [2];
    leg_t             gate_leg [2];

    chop_cycle_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .cnt  (cnt),
        .wrap (wrap)
    );

    chop_phase_ctrl #(
        .PERIOD_CYC (PERIOD_CYC),
        .BLANK_CYC  (BLANK_CYC),
        .MIX_AT     (MIX_AT),
        .CNT_W      (CNT_W)
    ) u_phase (
        .clk         (clk),
        .rst         (rst),
        .run         (enable),
        .cnt         (cnt),
        .wrap        (wrap),
        .level_zero  (level == '0),
        .mixed_sel   (mixed_sel),
        .cur_falling (cur_falling),
        .trip        (trip),
        .zero_hit    (zero_hit),
        .phase       (phase)
    );

    assign req        = phase_gates(phase, dir_pos);
    assign req_leg[0] = req.leg1;
    assign req_leg[1] = req.leg2;

    for (genvar g = 0; g < 2; g++) begin : g_leg
        chop_dead_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk  (clk),
            .rst  (rst),
            .req  (req_leg[g]),
            .gate (gate_leg[g])
        );
    end

    assign hs1 = gate_leg[0].hs;
    assign ls1 = gate_leg[0].ls;
    assign hs2 = gate_leg[1].hs;
    assign ls2 = gate_leg[1].ls;

    assert_disable_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable && $past(!enable)) |=> !(hs1 || ls1 || hs2 || ls2));

    assert_one_path_R10: assert property (@(posedge clk) disable iff (rst)
        !(hs1 && hs2) && !(ls1 && hs1) && !(ls2 && hs2));

endmodule

// File: tb/chop_winding_ctrl_test.sv
module chop_winding_ctrl_test;

    localparam int PERIOD = 40;
    localparam int BLANK  = 6;
    localparam int MIXP   = 75;
    localparam int DEAD   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       dir_pos = 1'b1;
    logic [2:0] level = 3'd5;
    logic       mixed_sel = 1'b0;
    logic       cur_falling = 1'b0;
    logic       trip = 1'b0;
    logic       zero_hit = 1'b0;
    logic       hs1, ls1, hs2, ls2;

    int n_checks = 0;
    int n_fail   = 0;
    int tick     = 0;

    typedef struct {
        int         at;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    chop_winding_ctrl #(
        .PERIOD_CYC (PERIOD),
        .BLANK_CYC  (BLANK),
        .MIX_PCT    (MIXP),
        .DEAD_CYC   (DEAD),
        .LVL_W      (3)
    ) uut (
        .clk (clk), .rst (rst), .enable (enable), .dir_pos (dir_pos),
        .level (level), .mixed_sel (mixed_sel), .cur_falling (cur_falling),
        .trip (trip), .zero_hit (zero_hit),
        .hs1 (hs1), .ls1 (ls1), .hs2 (hs2), .ls2 (ls2)
    );

    always #10 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    task automatic compare(input logic [3:0] exp, input string r);
        logic [3:0] act;
        act = {hs1, ls1, hs2, ls2};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at tick %0d: gates actual %b expected %b", r, tick, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items as their tick arrives.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= tick) begin
                compare(sb[0].exp, sb[0].req);
                void'(sb.pop_front());
            end
        end
    end

    task automatic expect_at(input int at, input logic [3:0] v, input string r);
        item_t it;
        it.at = at; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic wait_tick(input int n);
        while (tick < n) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic start_run(input logic d, input logic [2:0] lv, input logic mx,
                             input logic fall, input logic tr, output int t0);
        @(negedge clk);
        rst = 1'b1; enable = 1'b0; trip = 1'b0; zero_hit = 1'b0;
        dir_pos = d; level = lv; mixed_sel = mx; cur_falling = fall;
        @(negedge clk);
        @(negedge clk);
        compare(4'b0000, "R11");
        rst = 1'b0; enable = 1'b1; trip = tr;
        t0 = tick;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at tick %0d: actual running expected finished", tick);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int t;
        // Slow decay with trip held from the start: blanking, dead time, wrap.
        start_run(1'b1, 3'd5, 1'b0, 1'b0, 1'b1, t);
        expect_at(t + 2,  4'b1001, "R3");
        expect_at(t + 7,  4'b1001, "R2");
        expect_at(t + 8,  4'b0001, "R10");
        expect_at(t + 9,  4'b0001, "R10");
        expect_at(t + 10, 4'b0101, "R4");
        expect_at(t + 41, 4'b0101, "R1");
        expect_at(t + 42, 4'b0001, "R10");
        expect_at(t + 44, 4'b1001, "R1");
        drain();

        // Mixed decay on a falling step: fast then slow at the mix point.
        start_run(1'b1, 3'd5, 1'b1, 1'b1, 1'b0, t);
        expect_at(t + 12, 4'b1001, "R5");
        expect_at(t + 13, 4'b0000, "R10");
        expect_at(t + 15, 4'b0110, "R5");
        expect_at(t + 31, 4'b0110, "R5");
        expect_at(t + 32, 4'b0100, "R5");
        expect_at(t + 34, 4'b0101, "R5");
        wait_tick(t + 11); trip = 1'b1;
        drain();

        // Mixed selected but current rising: slow decay.
        start_run(1'b1, 3'd5, 1'b1, 1'b0, 1'b0, t);
        expect_at(t + 13, 4'b0001, "R4");
        expect_at(t + 15, 4'b0101, "R4");
        wait_tick(t + 11); trip = 1'b1;
        drain();

        // Zero crossing during fast decay.
        start_run(1'b1, 3'd5, 1'b1, 1'b1, 1'b0, t);
        expect_at(t + 17, 4'b0110, "R7");
        expect_at(t + 18, 4'b0000, "R7");
        expect_at(t + 34, 4'b0000, "R7");
        wait_tick(t + 11); trip = 1'b1;
        wait_tick(t + 16); zero_hit = 1'b1;
        drain();

        // Zero level: slow decay for the whole cycle.
        start_run(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, t);
        expect_at(t + 2,  4'b0101, "R8");
        expect_at(t + 30, 4'b0101, "R8");
        expect_at(t + 42, 4'b0101, "R8");
        drain();

        // Trip after the mix point in mixed mode.
        start_run(1'b1, 3'd5, 1'b1, 1'b1, 1'b0, t);
        expect_at(t + 32, 4'b1001, "R6");
        expect_at(t + 33, 4'b0001, "R6");
        expect_at(t + 35, 4'b0101, "R6");
        wait_tick(t + 31); trip = 1'b1;
        drain();

        // Negative direction, no trip, then disable and re-enable.
        start_run(1'b0, 3'd5, 1'b0, 1'b0, 1'b0, t);
        expect_at(t + 2,  4'b0110, "R3");
        expect_at(t + 20, 4'b0110, "R2");
        expect_at(t + 22, 4'b0110, "R9");
        expect_at(t + 23, 4'b0000, "R9");
        expect_at(t + 27, 4'b0110, "R9");
        wait_tick(t + 21); enable = 1'b0;
        wait_tick(t + 25); enable = 1'b1;
        drain();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule